// File: doc/BRIEF.md
# Stall-Gated Stream Input Adapter

This block connects an upstream stream source that speaks a valid/ready handshake to a processing core that only knows a data word, a valid strobe and a clock enable. Beats that the source hands over reach the core in the same cycle. When the consumer behind the core lowers its ready, the adapter switches the core's enable off and drops the upstream ready, which freezes the whole pipeline instead of buffering it.

A source that registers ready can put one more beat on the bus in the cycle after ready falls. The adapter keeps that beat in a single holding register. When the enable comes back, the held beat goes to the core first, and only in the following cycle does upstream ready rise again. A beat offered while ready has been low for both the current and the previous cycle is not taken.

A mode parameter builds a variant for designs with several streams. That variant has no back pressure: upstream ready and the core enable stay high, the downstream ready is ignored, and beats go straight through. Beats can be lost in that mode.

Top module: `stream_stall_adapter`

## Requirements
- R1: In single-stream mode `core_en` equals `dn_ready`; whenever `dn_ready` is low, both `core_en` and `s_tready` are low.
- R2: A beat with `s_tvalid` high in a cycle where `s_tready` is low but was high in the previous clock cycle is captured, and it is later delivered to the core.
- R3: A beat offered while `s_tready` is low in both the current and the previous cycle never reaches the core.
- R4: With nothing held and `dn_ready` high, `s_tready` is high, and an offered beat appears on `core_valid`/`core_data` in that same cycle.
- R5: In the first cycle that `dn_ready` is high while a beat is held, the core gets the held beat and `s_tready` stays low. The hold is then empty.
- R6: Beats reach the core exactly once each and in the order they were accepted upstream, whatever the stall pattern.
- R7: With `MODE` set to multi-stream, `s_tready` and `core_en` are always high, `dn_ready` has no effect, and `core_valid`/`core_data` follow `s_tvalid`/`s_tdata` in the same cycle.
- R8: `core_valid` is high only while `core_en` is high, and `core_data` is all zeros whenever `core_valid` is low.
- R9: Reset is synchronous and active low. While it is asserted, `s_tready` is low in single-stream mode. It empties the holding register, so a beat held before reset is never delivered, and the cycle just before release counts as a cycle with `s_tready` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s_tdata | input | DATA_W | Upstream data word |
| s_tvalid | input | 1 | Upstream beat valid |
| s_tready | output | 1 | Upstream ready |
| dn_ready | input | 1 | Ready from the downstream consumer |
| core_en | output | 1 | Clock enable for the core |
| core_valid | output | 1 | Core-side beat valid |
| core_data | output | DATA_W | Core-side data word, zero when not valid |

## Verification
The hardest state to reach is a held late beat that meets a second stall before it has been replayed, with the source still offering beats. That calls for a ready that rises and falls within a few cycles, together with a source that keeps pushing through the closed window. The bench sweeps every four-cycle combination of downstream ready and source intent, and each intent turns into either a legal beat or a marked rogue beat, depending on the ready the source saw. A long random run follows, with a reset while a beat is held. A queue-based reference model checks order and catches any rogue beat that leaks through.

// File: rtl/ssa_pkg.sv
package ssa_pkg;
    typedef enum logic {
        SSA_SINGLE = 1'b0,
        SSA_MULTI  = 1'b1
    } ssa_mode_e;
endpackage

// File: rtl/ssa_accept_window.sv
// Remembers whether upstream ready was high one cycle ago and flags a late beat.
module ssa_accept_window (
    input  logic clk,
    input  logic rst_n,
    input  logic rdy_now,
    input  logic beat_vld,
    output logic late
);
    typedef struct packed {
        logic rdy_prev;
    } win_t;

    win_t win_d, win_q;

    always_comb begin
        win_d          = win_q;
        win_d.rdy_prev = rdy_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign late = beat_vld & ~rdy_now & win_q.rdy_prev;
endmodule

// File: rtl/ssa_hold_reg.sv
// One-entry store for the beat that arrives after ready falls.
module ssa_hold_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [DATA_W-1:0] cap_data,
    input  logic              drain,
    output logic              hold_v,
    output logic [DATA_W-1:0] hold_data
);
    typedef struct packed {
        logic              v;
        logic [DATA_W-1:0] data;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (drain) hold_d.v = 1'b0;
        if (cap) begin
            hold_d.v    = 1'b1;
            hold_d.data = cap_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign hold_v    = hold_q.v;
    assign hold_data = hold_q.data;
endmodule

// File: rtl/ssa_core_mux.sv
// Selects the held beat ahead of a pass-through beat for the core.
module ssa_core_mux #(
    parameter int DATA_W = 32
) (
    input  logic              en,
    input  logic              hold_v,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              pass_vld,
    input  logic [DATA_W-1:0] pass_data,
    output logic              core_valid,
    output logic [DATA_W-1:0] core_data,
    output logic              drain
);
    always_comb begin
        core_valid = 1'b0;
        core_data  = '0;
        drain      = 1'b0;
        if (en && hold_v) begin
            core_valid = 1'b1;
            core_data  = hold_data;
            drain      = 1'b1;
        end else if (en && pass_vld) begin
            core_valid = 1'b1;
            core_data  = pass_data;
        end
    end
endmodule

// File: rtl/stream_stall_adapter.sv
module stream_stall_adapter #(
    parameter int               DATA_W = 32,
    parameter ssa_pkg::ssa_mode_e MODE = ssa_pkg::SSA_SINGLE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic              s_tvalid,
    output logic              s_tready,
    input  logic              dn_ready,
    output logic              core_en,
    output logic              core_valid,
    output logic [DATA_W-1:0] core_data
);
    logic              hold_v;
    logic [DATA_W-1:0] hold_data;
    logic              drain;

    generate
        if (MODE == ssa_pkg::SSA_SINGLE) begin : g_single
            logic late;

            assign s_tready = rst_n & dn_ready & ~hold_v;
            assign core_en  = dn_ready;

            ssa_accept_window win_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .rdy_now  (s_tready),
                .beat_vld (s_tvalid),
                .late     (late)
            );

            ssa_hold_reg #(.DATA_W(DATA_W)) hold_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .cap       (late),
                .cap_data  (s_tdata),
                .drain     (drain),
                .hold_v    (hold_v),
                .hold_data (hold_data)
            );

            ssa_core_mux #(.DATA_W(DATA_W)) mux_i (
                .en         (dn_ready),
                .hold_v     (hold_v),
                .hold_data  (hold_data),
                .pass_vld   (s_tvalid & s_tready),
                .pass_data  (s_tdata),
                .core_valid (core_valid),
                .core_data  (core_data),
                .drain      (drain)
            );
        end else begin : g_multi
            logic unused_multi;

            assign unused_multi = dn_ready ^ rst_n ^ clk ^ drain;
            assign s_tready     = 1'b1;
            assign core_en      = 1'b1;
            assign hold_v       = 1'b0;
            assign hold_data    = '0;

            ssa_core_mux #(.DATA_W(DATA_W)) mux_i (
                .en         (1'b1),
                .hold_v     (hold_v),
                .hold_data  (hold_data),
                .pass_vld   (s_tvalid),
                .pass_data  (s_tdata),
                .core_valid (core_valid),
                .core_data  (core_data),
                .drain      (drain)
            );
        end
    endgenerate
endmodule

// File: rtl/ssa_checker.sv
module ssa_checker #(
    parameter int               DATA_W = 32,
    parameter ssa_pkg::ssa_mode_e MODE = ssa_pkg::SSA_SINGLE
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] s_tdata,
    input logic              s_tvalid,
    input logic              s_tready,
    input logic              dn_ready,
    input logic              core_en,
    input logic              core_valid,
    input logic [DATA_W-1:0] core_data,
    input logic              hold_v,
    input logic [DATA_W-1:0] hold_data
);
    logic past_ok_q = 1'b0;
    always_ff @(posedge clk) past_ok_q <= rst_n;

    a_r8_valid_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        core_valid |-> core_en);

    a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !core_valid |-> core_data == '0);

    generate
        if (MODE == ssa_pkg::SSA_SINGLE) begin : g_single_chk
            a_r1_stall_gates: assert property (@(posedge clk) disable iff (!rst_n)
                !dn_ready |-> (!core_en && !s_tready));

            a_r2_late_captured: assert property (@(posedge clk) disable iff (!rst_n)
                (past_ok_q && s_tvalid && !s_tready && $past(s_tready))
                |=> (hold_v && hold_data == $past(s_tdata)));

            a_r3_closed_window: assert property (@(posedge clk) disable iff (!rst_n)
                (past_ok_q && !s_tready && !$past(s_tready))
                |-> (!core_valid || hold_v));

            a_r3_no_new_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (past_ok_q && !s_tready && !$past(s_tready) && !hold_v) |=> !hold_v);

            a_r5_replay_first: assert property (@(posedge clk) disable iff (!rst_n)
                (hold_v && core_en) |-> (core_valid && core_data == hold_data && !s_tready));

            a_r5_hold_drains: assert property (@(posedge clk) disable iff (!rst_n)
                (hold_v && core_en) |=> !hold_v);

            a_r9_reset_closed: assert property (@(posedge clk)
                !rst_n |-> !s_tready);
        end else begin : g_multi_chk
            a_r7_multi_open: assert property (@(posedge clk) disable iff (!rst_n)
                s_tready && core_en && (core_valid == s_tvalid));

            a_r7_multi_data: assert property (@(posedge clk) disable iff (!rst_n)
                core_valid |-> core_data == s_tdata);
        end
    endgenerate
endmodule

bind stream_stall_adapter ssa_checker #(.DATA_W(DATA_W), .MODE(MODE)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .s_tdata    (s_tdata),
    .s_tvalid   (s_tvalid),
    .s_tready   (s_tready),
    .dn_ready   (dn_ready),
    .core_en    (core_en),
    .core_valid (core_valid),
    .core_data  (core_data),
    .hold_v     (hold_v),
    .hold_data  (hold_data)
);

// File: tb/stream_stall_adapter_tb_top.sv
module stream_stall_adapter_tb_top;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [DW-1:0] s_tdata;
    logic          s_tvalid;
    logic          dn_ready;
    logic          s_tready, core_en, core_valid;
    logic [DW-1:0] core_data;
    logic          m_tready, m_en, m_valid;
    logic [DW-1:0] m_data;

    int n_checks = 0;
    int n_errors = 0;
    int n_late   = 0;

    logic [DW-1:0] exp_q[$];
    logic          rdy_prev;
    logic          pend;
    logic [DW-1:0] pend_data;
    logic [DW-1:0] seq;
    logic [DW-1:0] rogue_n;

    always #10 clk = ~clk;

    stream_stall_adapter #(.DATA_W(DW), .MODE(ssa_pkg::SSA_SINGLE)) dut_i (
        .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
        .s_tready(s_tready), .dn_ready(dn_ready), .core_en(core_en),
        .core_valid(core_valid), .core_data(core_data)
    );

    stream_stall_adapter #(.DATA_W(DW), .MODE(ssa_pkg::SSA_MULTI)) dut_m_i (
        .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
        .s_tready(m_tready), .dn_ready(dn_ready), .core_en(m_en),
        .core_valid(m_valid), .core_data(m_data)
    );

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        dn_ready = 1'b1;
        s_tvalid = 1'b0;
        repeat (2) @(negedge clk);
        #5;
        chk(s_tready == 1'b0, "R9 tready low in reset", {31'b0, s_tready}, 0);
        chk(core_valid == 1'b0, "R9 no core beat in reset", {31'b0, core_valid}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        exp_q.delete();
        pend = 1'b0;
        #5;
        chk(s_tready == dn_ready, "R9 hold empty after reset", {31'b0, s_tready}, {31'b0, dn_ready});
        rdy_prev = s_tready;
    endtask

    task automatic step(input logic rdy, input logic want);
        logic          rdy_now, pend_start, legit;
        logic [DW-1:0] got;
        @(negedge clk);
        dn_ready = rdy;
        #1;
        rdy_now    = s_tready;
        pend_start = pend;
        legit      = 1'b0;
        if (want && (rdy_now || rdy_prev)) begin
            s_tvalid = 1'b1; s_tdata = seq; legit = 1'b1;
        end else if (want) begin
            s_tvalid = 1'b1; s_tdata = 32'hBAD0_0000 | rogue_n; rogue_n++;
        end else begin
            s_tvalid = 1'b0; s_tdata = $urandom;
        end
        #4;
        chk(core_en == rdy, "R1 enable follows ready", {31'b0, core_en}, {31'b0, rdy});
        if (!rdy)
            chk(s_tready == 1'b0, "R1 tready low in stall", {31'b0, s_tready}, 0);
        if (pend_start && rdy) begin
            chk(s_tready == 1'b0, "R5 tready low during replay", {31'b0, s_tready}, 0);
            chk(core_valid && core_data == pend_data, "R5 held beat first",
                core_data, pend_data);
            pend = 1'b0;
        end
        if (!pend_start && rdy)
            chk(s_tready == 1'b1, "R4 tready high when idle", {31'b0, s_tready}, 1);
        if (legit) begin
            exp_q.push_back(seq);
            if (!rdy) begin
                chk(!pend_start, "R2 late beat fits hold", {31'b0, pend_start}, 0);
                pend = 1'b1; pend_data = seq; n_late++;
            end else if (!pend_start) begin
                chk(core_valid && core_data == seq, "R4 pass-through", core_data, seq);
            end
            seq++;
        end
        if (s_tvalid && !legit)
            chk(!(core_valid && core_data == s_tdata), "R3 rogue beat ignored",
                core_data, s_tdata);
        if (core_valid) begin
            chk(core_en, "R8 valid implies enable", {31'b0, core_en}, 1);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 unexpected core beat", core_data, 0);
            end else begin
                got = exp_q.pop_front();
                chk(core_data == got, "R6 order", core_data, got);
            end
        end else begin
            chk(core_data == '0, "R8 idle data zero", core_data, 0);
        end
        chk(m_tready && m_en, "R7 multi always open", {30'b0, m_tready, m_en}, 3);
        chk(m_valid == s_tvalid && (!s_tvalid || m_data == s_tdata), "R7 multi passthrough",
            m_data, s_tvalid ? s_tdata : '0);
        rdy_prev = rdy_now;
    endtask

    initial begin
        #(20 * 200000);
        n_errors++;
        $display("FAIL R6 watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; s_tvalid = 1'b0; s_tdata = '0; dn_ready = 1'b1;
        seq = 32'd1; rogue_n = '0; pend = 1'b0; rdy_prev = 1'b0;
        do_reset();

        for (int pat = 0; pat < 256; pat++) begin
            for (int k = 0; k < 4; k++)
                step(pat[k], pat[k + 4]);
        end

        for (int i = 0; i < 4000; i++) begin
            int dens;
            dens = (i / 500) % 4;
            step(($urandom % 4) >= dens, ($urandom % 4) != 0);
        end

        repeat (4) step(1'b1, 1'b0);
        chk(exp_q.size() == 0, "R6 all beats delivered", exp_q.size(), 0);
        chk(n_late > 0, "R2 late beats seen", n_late, 1);

        step(1'b1, 1'b1);
        step(1'b0, 1'b1);
        chk(pend == 1'b1, "R2 hold loaded before reset", {31'b0, pend}, 1);
        do_reset();
        step(1'b1, 1'b0);
        chk(core_valid == 1'b0, "R9 held beat dropped by reset", {31'b0, core_valid}, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule